// File: doc/BRIEF.md
# Arithmetic Unit with Status Flags

This block performs eight integer operations on byte-wide or word-wide operands: add, add with carry-in, increment, subtract, subtract with borrow-in, decrement, two's-complement negate and compare. The result is formed combinationally from the present operands and the stored carry. A six-bit flag register captures overflow, sign, zero, auxiliary carry, parity and carry on every clock edge where the valid strobe is high.

A sequencer presents one operation per cycle. It writes `resultOut` to its destination whenever `writeEn` is high, and reads the flags after the edge. To chain wide arithmetic, issue the low part first with add or subtract, then the high part with the carry-in or borrow-in variant. Increment and decrement leave the carry untouched, so loop counters can sit inside such a chain without breaking it.

Top module: `arith_flag_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `flagsOut` is all zeros. Bit layout of `flagsOut`: [5] overflow, [4] sign, [3] zero, [2] auxiliary carry, [1] parity, [0] carry.
- R2: Opcode 0 gives dst+src and opcode 1 gives dst+src+carry. The new carry is the unsigned carry out of the operand's top bit.
- R3: Opcode 3 gives dst−src and opcode 4 gives dst−src−carry. The new carry is the unsigned borrow (dst < src + carry-in), independent of any signed reading.
- R4: Opcode 2 gives dst+1 and opcode 5 gives dst−1. The carry flag keeps its prior value, for example across incrementing 0xFF to 0x00.
- R5: Opcode 6 gives 0−dst. The carry becomes 1 for any nonzero operand and 0 for a zero operand.
- R6: Overflow is set when the signed result does not fit the selected size. For negate this happens only for 0x80 in byte mode or 0x8000 in word mode.
- R7: Opcode 7 updates all six flags exactly as opcode 3 would for the same operands, and `writeEn` stays low.
- R8: Auxiliary carry is the carry (for add-type operations) or borrow (for subtract-type operations) from bit 3 into bit 4, in both sizes.
- R9: Parity is 1 when result bits [7:0] hold an even count of ones. Zero is 1 when the sized result is zero. Sign is the top bit of the sized result.
- R10: With `wordSel`=0 only operand bits [7:0] are used, `resultOut[15:8]` is zero, and sign, overflow and carry are taken at bit 7. With `wordSel`=1 they are taken at bit 15.
- R11: When `opValid` is low, `flagsOut` holds its value across the edge and `writeEn` is low. Otherwise `writeEn` is high for every opcode except 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation strobe; flags load on edges where high |
| opCode | input | 3 | Operation select (see R2–R7) |
| wordSel | input | 1 | 1 = 16-bit operands, 0 = 8-bit operands |
| dstIn | input | 16 | Destination operand |
| srcIn | input | 16 | Source operand |
| resultOut | output | 16 | Combinational result for the presented operation |
| writeEn | output | 1 | Destination write enable |
| flagsOut | output | 6 | Registered status flags |

## Verification
Byte mode is swept with every destination value against sixteen source values spread over the range, for all eight opcodes. This covers each nibble-carry and sign-crossing combination, and lets the carry left by one operation feed the next carry-in or borrow-in, so both carry-in states occur. A coarser word-mode grid, together with the limit values 0x7FFF, 0x8000 and 0xFFFF, separates bit-15 evaluation from bit-7 evaluation. Directed cases pin down the remaining behaviours: increment of 0xFF with each prior carry state, negate of zero and of the most negative value, compare leaving the destination unwritten, and idle cycles leaving the flags untouched.

// File: rtl/arith_pkg.sv
package arith_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_INC = 3'd2,
    OP_SUB = 3'd3,
    OP_SBB = 3'd4,
    OP_DEC = 3'd5,
    OP_NEG = 3'd6,
    OP_CMP = 3'd7
  } arith_op_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic subtract;     // a - b - cin instead of a + b + cin
    logic useCarry;     // stored carry feeds the carry/borrow input
    logic keepCarry;    // carry flag is not updated
    logic negate;       // a = 0, b = destination
    logic unitOperand;  // b = 1
    logic storeResult;  // destination is written
  } arith_ctrl_t;

  typedef struct packed {
    logic overflow;
    logic sign;
    logic zero;
    logic aux;
    logic parity;
    logic carry;
  } arith_flags_t;

endpackage

// File: rtl/arith_ctrl.sv
module arith_ctrl
  import arith_pkg::*;
(
  input  arith_op_e   opCode,
  output arith_ctrl_t ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.storeResult = 1'b1;
    unique case (opCode)
      OP_ADD: ;
      OP_ADC: ctrl.useCarry = 1'b1;
      OP_INC: begin
        ctrl.unitOperand = 1'b1;
        ctrl.keepCarry   = 1'b1;
      end
      OP_SUB: ctrl.subtract = 1'b1;
      OP_SBB: begin
        ctrl.subtract = 1'b1;
        ctrl.useCarry = 1'b1;
      end
      OP_DEC: begin
        ctrl.subtract    = 1'b1;
        ctrl.unitOperand = 1'b1;
        ctrl.keepCarry   = 1'b1;
      end
      OP_NEG: begin
        ctrl.subtract = 1'b1;
        ctrl.negate   = 1'b1;
      end
      OP_CMP: begin
        ctrl.subtract    = 1'b1;
        ctrl.storeResult = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/arith_datapath.sv
module arith_datapath
  import arith_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  arith_ctrl_t       ctrl,
  input  logic              wordSel,
  input  logic [DATA_W-1:0] dstIn,
  input  logic [DATA_W-1:0] srcIn,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output arith_flags_t      flagsNext
);

  localparam int EXT_W   = DATA_W + 1;
  localparam int NIB_W   = 4;
  localparam int UPPER_W = DATA_W - BYTE_W;

  logic [DATA_W-1:0] opMask;
  logic [DATA_W-1:0] dstM, srcM, opA, opB, resM;
  logic [EXT_W-1:0]  ext, cinExt;
  logic              cin, aSign, bSign, rSign, cOut, ovf;

  assign opMask = wordSel ? {DATA_W{1'b1}} : {{UPPER_W{1'b0}}, {BYTE_W{1'b1}}};
  assign dstM   = dstIn & opMask;
  assign srcM   = srcIn & opMask;

  always_comb begin
    opA = ctrl.negate ? '0 : dstM;
    if (ctrl.negate)           opB = dstM;
    else if (ctrl.unitOperand) opB = {{(DATA_W-1){1'b0}}, 1'b1};
    else                       opB = srcM;
  end

  assign cin    = ctrl.useCarry & carryIn;
  assign cinExt = {{DATA_W{1'b0}}, cin};
  assign ext    = ctrl.subtract ? ({1'b0, opA} - {1'b0, opB} - cinExt)
                                : ({1'b0, opA} + {1'b0, opB} + cinExt);
  assign resM   = ext[DATA_W-1:0] & opMask;
  assign result = resM;

  // Size-dependent bit taps
  assign aSign = wordSel ? opA[DATA_W-1] : opA[BYTE_W-1];
  assign bSign = wordSel ? opB[DATA_W-1] : opB[BYTE_W-1];
  assign rSign = wordSel ? resM[DATA_W-1] : resM[BYTE_W-1];
  assign cOut  = wordSel ? ext[DATA_W] : ext[BYTE_W];

  assign ovf = ctrl.subtract ? ((aSign != bSign) && (rSign != aSign))
                             : ((aSign == bSign) && (rSign != aSign));

  always_comb begin
    flagsNext.overflow = ovf;
    flagsNext.sign     = rSign;
    flagsNext.zero     = (resM == '0);
    flagsNext.aux      = opA[NIB_W] ^ opB[NIB_W] ^ ext[NIB_W];
    flagsNext.parity   = ~^resM[BYTE_W-1:0];
    flagsNext.carry    = ctrl.keepCarry ? carryIn : cOut;
  end

endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import arith_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic              wordSel,
  input  logic [DATA_W-1:0] dstIn,
  input  logic [DATA_W-1:0] srcIn,
  output logic [DATA_W-1:0] resultOut,
  output logic              writeEn,
  output logic [5:0]        flagsOut
);

  arith_ctrl_t  ctrl;
  arith_flags_t flagsReg, flagsNext;

  arith_ctrl u_ctrl (
    .opCode (arith_op_e'(opCode)),
    .ctrl   (ctrl)
  );

  arith_datapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dp (
    .ctrl      (ctrl),
    .wordSel   (wordSel),
    .dstIn     (dstIn),
    .srcIn     (srcIn),
    .carryIn   (flagsReg.carry),
    .result    (resultOut),
    .flagsNext (flagsNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        flagsReg <= '0;
    else if (opValid) flagsReg <= flagsNext;
  end

  assign writeEn  = opValid & ctrl.storeResult;
  assign flagsOut = flagsReg;

  logic negNonZero;
  assign negNonZero = wordSel ? (dstIn != '0) : (dstIn[BYTE_W-1:0] != '0);

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd7) |-> !writeEn); // R7

  AST_KEEP_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == 3'd2 || opCode == 3'd5)) |=> (flagsOut[0] == $past(flagsOut[0]))); // R4

  AST_NEG_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd6) |=> (flagsOut[0] == $past(negNonZero))); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(flagsOut)); // R11

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> (flagsOut[3] == ($past(resultOut) == '0))); // R9

endmodule

// File: tb/sim_arith_flag_unit.sv
`timescale 1ns/1ps
module sim_arith_flag_unit;

  localparam int HALF_NS = 2.5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic        wordSel = 1'b0;
  logic [15:0] dstIn = '0;
  logic [15:0] srcIn = '0;
  logic [15:0] resultOut;
  logic        writeEn;
  logic [5:0]  flagsOut;

  int checks = 0;
  int errors = 0;
  int modelCf = 0;
  logic [5:0] modelFlags = '0;

  always #2.5 clk = ~clk;

  arith_flag_unit u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .wordSel(wordSel), .dstIn(dstIn), .srcIn(srcIn),
    .resultOut(resultOut), .writeEn(writeEn), .flagsOut(flagsOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Arithmetic reference model on plain integers
  task automatic model(input int op, input int word, input int d, input int s,
                       input int cf, output int res, output logic [5:0] fl);
    int w, mask, half, a, b, c, r, sa, sb, sr, ones;
    bit isSub, carry, aux, ovf, sign, zero, par;
    w = word ? 16 : 8;
    mask = (1 << w) - 1;
    half = 1 << (w - 1);
    a = d & mask; b = s & mask; c = 0;
    isSub = (op >= 3 && op != 5) || op == 5;
    case (op)
      0: ;
      1: c = cf;
      2: b = 1;
      3: ;
      4: c = cf;
      5: b = 1;
      6: begin b = d & mask; a = 0; end
      default: ;
    endcase
    isSub = (op >= 3);
    r = isSub ? a - b - c : a + b + c;
    carry = isSub ? (r < 0) : (r > mask);
    aux = isSub ? (((a & 15) - (b & 15) - c) < 0) : (((a & 15) + (b & 15) + c) > 15);
    sa = (a >= half) ? a - 2 * half : a;
    sb = (b >= half) ? b - 2 * half : b;
    sr = isSub ? sa - sb - c : sa + sb + c;
    ovf = (sr < -half) || (sr > half - 1);
    res = r & mask;
    sign = (res >> (w - 1)) & 1;
    zero = (res == 0);
    ones = 0;
    for (int i = 0; i < 8; i++) ones += (res >> i) & 1;
    par = (ones % 2) == 0;
    if (op == 2 || op == 5) carry = cf[0];
    fl = {ovf, sign, zero, aux, par, carry};
  endtask

  function automatic string resTag(input int op);
    case (op)
      0, 1: return "R2";
      2, 5: return "R4";
      3, 4: return "R3";
      6: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic runOp(input int op, input int word, input int d, input int s);
    int expRes;
    logic [5:0] expFl;
    @(negedge clk);
    opValid = 1'b1; opCode = op[2:0]; wordSel = word[0];
    dstIn = d[15:0]; srcIn = s[15:0];
    model(op, word, d, s, modelCf, expRes, expFl);
    #1;
    if (op != 7) check({resTag(op), " result"}, int'(resultOut), expRes);
    check("R7 R11 writeEn", int'(writeEn), (op != 7) ? 1 : 0);
    if (!word) check("R10 upper byte", int'(resultOut[15:8]), 0);
    @(posedge clk); #1;
    opValid = 1'b0;
    check({resTag(op), " carry"}, int'(flagsOut[0]), int'(expFl[0]));
    check("R6 overflow", int'(flagsOut[5]), int'(expFl[5]));
    check("R8 aux", int'(flagsOut[2]), int'(expFl[2]));
    check("R9 sign/zero/parity", int'({flagsOut[4], flagsOut[3], flagsOut[1]}),
          int'({expFl[4], expFl[3], expFl[1]}));
    modelFlags = expFl;
    modelCf = int'(expFl[0]);
  endtask

  initial begin
    #(HALF_NS * 2 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset flags", int'(flagsOut), 0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 flags after reset", int'(flagsOut), 0);
    check("R11 writeEn idle", int'(writeEn), 0);

    // Documented example: 0x45 + 0xE3
    runOp(0, 0, 'h45, 'hE3);
    check("R9 example flags", int'(flagsOut), int'(6'b000011));

    // INC 0xFF with carry set, then with carry clear
    runOp(2, 0, 'hFF, 0);
    check("R4 inc keeps carry 1", int'(flagsOut[0]), 1);
    runOp(0, 0, 1, 1);
    runOp(2, 0, 'hFF, 0);
    check("R4 inc keeps carry 0", int'(flagsOut[0]), 0);
    check("R4 inc wraps to zero", int'(flagsOut[3]), 1);

    // NEG corner cases
    runOp(6, 0, 0, 0);
    check("R5 neg zero carry", int'(flagsOut[0]), 0);
    runOp(6, 0, 'h80, 0);
    check("R6 neg byte min overflow", int'(flagsOut[5]), 1);
    runOp(6, 1, 'h8000, 0);
    check("R6 neg word min overflow", int'(flagsOut[5]), 1);
    runOp(6, 1, 'h0080, 0);
    check("R10 word neg 0x80 no overflow", int'(flagsOut[5]), 0);

    // CMP same flags as SUB
    runOp(3, 0, 'h12, 'h34);
    begin
      logic [5:0] subFl;
      subFl = flagsOut;
      runOp(7, 0, 'h12, 'h34);
      check("R7 cmp flags equal sub", int'(flagsOut), int'(subFl));
    end

    // Idle cycles: flags hold even with changing inputs
    @(negedge clk);
    opValid = 1'b0; opCode = 3'd0; dstIn = 16'hFFFF; srcIn = 16'h0001;
    #1;
    check("R11 writeEn low when idle", int'(writeEn), 0);
    @(posedge clk); #1;
    check("R11 flags hold when idle", int'(flagsOut), int'(modelFlags));

    // Byte sweep
    for (int op = 0; op < 8; op++)
      for (int d = 0; d < 256; d++)
        for (int s = 0; s < 256; s += 17)
          runOp(op, 0, d, s);

    // Word grid plus limits
    for (int op = 0; op < 8; op++) begin
      for (int d = 0; d < 65536; d += 4099)
        for (int s = 0; s < 65536; s += 4099)
          runOp(op, 1, d, s);
      runOp(op, 1, 'h7FFF, 'hFFFF);
      runOp(op, 1, 'h8000, 'h0001);
      runOp(op, 1, 'hFFFF, 'h7FFF);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule